// File: doc/BRIEF.md
# Four-Channel Programmable Edge Delay Generator

This block is a clocked, all-digital model of a four-channel pulse delay line. Each channel samples a one-bit pulse stream and reproduces it on its output some number of clock cycles later. Each channel has its own 8-bit base delay code and its own 8-bit width-adjust code. A shared mode selector does two things. It sets the delay span, which is the largest delay count a code can reach. It also decides whether the falling edge can be moved apart from the rising edge. A merge control can OR channel 2's input into every channel, so that one stimulus drives all four outputs.

Each edge is scheduled when it arrives, as an entry in a small per-channel queue. The entry holds an absolute target time and the level to drive at that time. The mode and the codes are therefore read only at the moment an edge arrives. The queue never lets out an inverted pulse: when a falling edge would land at or before the rising edge it belongs to, both edges are dropped. A channel stays unarmed until it has seen one complete input pulse. While unarmed, it keeps its output low and schedules nothing.

Top module: `edge_dly_top`

## Requirements
- R1: While reset is high, and at the first sample after it, every `pulse_out` bit is 0 and every `not_armed` bit is 1.
- R2: `sel_hi` is a three-level select: 2'b00 = low, 2'b01 = high, 2'b10 = supply level, 2'b11 = reserved. The mode is decoded from {`sel_hi`, `sel_lo`} as follows: low/0 selects mode 0, low/1 mode 1, high/0 mode 2, high/1 mode 3 and supply/1 mode 5. Supply/0 and any reserved code are invalid, and `mode_bad` is 1 exactly when the selection is invalid.
- R3: With STEP = 2, the span S is 38 in modes 0 and 2, 62 in modes 1 and 3, and 90 in mode 5. In modes 0 and 1, both edges use the delay 1 + floor(code*(S-1)/255), and the width code has no effect.
- R4: In modes 2 and 3, the rising edge uses the base delay of R3. The falling edge uses base + width - 128, clamped to the range 1..S.
- R5: In mode 5, both edges use the delay 1 + floor((code+width)*(S-1)/510).
- R6: When `fanout_en` is 0, each channel uses its own input. When it is 1, each channel's effective input is its own bit ORed with `pulse_in[1]` (channel 2).
- R7: Until a channel has seen a rising edge followed by a falling edge on its effective input, it drives 0, holds its `not_armed` bit at 1 and schedules nothing. `not_armed` falls at the sample that sees the completing fall, and it never rises again.
- R8: An effective-input edge that is first sampled at clock k with delay d appears on `pulse_out` at clock k+d.
- R9: A falling edge whose target is not later than that of its still-queued rising edge removes that rising edge and is itself discarded.
- R10: A rising edge is discarded, together with the falling edge that follows it, in three cases: its target is not later than the queued edge before it, fewer than two queue slots are free, or the mode is invalid. In an invalid mode a falling edge uses delay 1.
- R11: The mode and the codes are read at the clock where an edge arrives. Later changes leave edges that are already queued unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_lo | input | 1 | Two-level mode select bit |
| sel_hi | input | 2 | Three-level mode select (00 low, 01 high, 10 supply, 11 reserved) |
| fanout_en | input | 1 | Merge channel 2 input into all channels |
| dly_code | input | NUM_CH*CODE_W | Base delay codes, channel c at bits [c*CODE_W +: CODE_W] |
| wid_code | input | NUM_CH*CODE_W | Width-adjust codes, same packing |
| pulse_in | input | NUM_CH | Input pulse streams |
| pulse_out | output | NUM_CH | Delayed pulse streams |
| not_armed | output | NUM_CH | Channel has not yet seen a full pulse |
| mode_bad | output | 1 | Current select combination is invalid |

## Verification
The main collision is between a queued edge leaving the queue and a new edge being judged against that same queue, both within one clock. This happens when a rising edge arrives in the very cycle that the previous falling edge fires, and when a falling edge arrives just as the queue is almost full. Back-to-back one-cycle pulses on a long delay fill the queue, and the random phase changes modes and codes while edges are still in flight. A cycle-accurate bench model of the queue then judges each output bit and each `not_armed` bit at every clock.

// File: rtl/edge_dly_pkg.sv
`timescale 1ns/1ps
package edge_dly_pkg;

    localparam int SPAN_SHORT_NS = 19;
    localparam int SPAN_LONG_NS  = 31;
    localparam int SPAN_EXT_NS   = 45;

    typedef enum logic [1:0] {
        SEL_LOW    = 2'b00,
        SEL_HIGH   = 2'b01,
        SEL_SUPPLY = 2'b10,
        SEL_RSVD   = 2'b11
    } sel3_e;

    typedef enum logic [2:0] {
        MODE_SHORT       = 3'd0,
        MODE_LONG        = 3'd1,
        MODE_SPLIT_SHORT = 3'd2,
        MODE_SPLIT_LONG  = 3'd3,
        MODE_EXTENDED    = 3'd5,
        MODE_INVALID     = 3'd7
    } dmode_e;

    function automatic int span_units(dmode_e m);
        case (m)
            MODE_SHORT, MODE_SPLIT_SHORT: return SPAN_SHORT_NS;
            MODE_LONG,  MODE_SPLIT_LONG:  return SPAN_LONG_NS;
            MODE_EXTENDED:                return SPAN_EXT_NS;
            default:                      return 0;
        endcase
    endfunction

    // linear map of num in 0..den onto 1..span
    function automatic int scale_delay(int num, int den, int span);
        if (span < 1) return 1;
        return 1 + (num * (span - 1)) / den;
    endfunction

    function automatic int clamp_range(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/edge_dly_mode_dec.sv
`timescale 1ns/1ps
module edge_dly_mode_dec
    import edge_dly_pkg::*;
(
    input  logic       sel_lo,
    input  logic [1:0] sel_hi,
    output dmode_e     mode,
    output logic       bad
);

    always_comb begin
        case (sel3_e'(sel_hi))
            SEL_LOW:    mode = sel_lo ? MODE_LONG : MODE_SHORT;
            SEL_HIGH:   mode = sel_lo ? MODE_SPLIT_LONG : MODE_SPLIT_SHORT;
            SEL_SUPPLY: mode = sel_lo ? MODE_EXTENDED : MODE_INVALID;
            default:    mode = MODE_INVALID;
        endcase
        bad = (mode == MODE_INVALID);
    end

endmodule

// File: rtl/edge_dly_calc.sv
`timescale 1ns/1ps
module edge_dly_calc
    import edge_dly_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int STEP   = 2,
    parameter int TIME_W = 8
) (
    input  dmode_e              mode,
    input  logic [CODE_W-1:0]   dly_code,
    input  logic [CODE_W-1:0]   wid_code,
    output logic [TIME_W-1:0]   rise_dly,
    output logic [TIME_W-1:0]   fall_dly,
    output logic                accept
);

    localparam int CODE_MAX = (2 ** CODE_W) - 1;
    localparam int CENTRE   = 2 ** (CODE_W - 1);

    int span;
    int base_d;
    int rise_i;
    int fall_i;

    always_comb begin
        span   = span_units(mode) * STEP;
        base_d = scale_delay(int'(32'(dly_code)), CODE_MAX, span);
        accept = 1'b1;
        case (mode)
            MODE_SHORT, MODE_LONG: begin
                rise_i = base_d;
                fall_i = base_d;
            end
            MODE_SPLIT_SHORT, MODE_SPLIT_LONG: begin
                rise_i = base_d;
                fall_i = clamp_range(base_d + int'(32'(wid_code)) - CENTRE, 1, span);
            end
            MODE_EXTENDED: begin
                rise_i = scale_delay(int'(32'(dly_code)) + int'(32'(wid_code)),
                                     2 * CODE_MAX, span);
                fall_i = rise_i;
            end
            default: begin
                rise_i = 1;
                fall_i = 1;
                accept = 1'b0;
            end
        endcase
        rise_dly = TIME_W'(rise_i);
        fall_dly = TIME_W'(fall_i);
    end

endmodule

// File: rtl/edge_dly_chan.sv
`timescale 1ns/1ps
module edge_dly_chan #(
    parameter int TIME_W = 8,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eff_in,
    input  logic [TIME_W-1:0] now,
    input  logic              accept,
    input  logic [TIME_W-1:0] rise_dly,
    input  logic [TIME_W-1:0] fall_dly,
    output logic              pout,
    output logic              not_armed
);

    localparam int PTR_W = $clog2(QDEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [TIME_W-1:0] tgt;
        logic              lvl;
    } ev_t;

    ev_t              q [QDEPTH];
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] cnt;
    logic             prev, armed, seen_rise, skip, pout_q;

    logic             rise_ev, fall_ev, fire;
    logic [PTR_W-1:0] last_idx;
    ev_t              last_ev, push_ev;
    logic [TIME_W-1:0] last_dist;
    logic             push, drop, set_skip, clr_skip;

    always_comb begin
        rise_ev   = eff_in & ~prev;
        fall_ev   = ~eff_in & prev;
        fire      = (cnt != '0) && (q[head].tgt == now);
        last_idx  = tail - 1'b1;
        last_ev   = q[last_idx];
        last_dist = last_ev.tgt - now;
        push      = 1'b0;
        drop      = 1'b0;
        set_skip  = 1'b0;
        clr_skip  = 1'b0;
        push_ev   = '0;
        if (armed) begin
            if (rise_ev) begin
                if (!accept || (cnt > CNT_W'(QDEPTH - 2)) ||
                    ((cnt != '0) && (rise_dly <= last_dist))) begin
                    set_skip = 1'b1;
                end else begin
                    push        = 1'b1;
                    push_ev.tgt = now + rise_dly;
                    push_ev.lvl = 1'b1;
                end
            end
            if (fall_ev) begin
                if (skip) begin
                    clr_skip = 1'b1;
                end else if ((cnt != '0) && last_ev.lvl && (fall_dly <= last_dist)) begin
                    drop = 1'b1;
                end else begin
                    push        = 1'b1;
                    push_ev.tgt = now + fall_dly;
                    push_ev.lvl = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
            head      <= '0;
            tail      <= '0;
            cnt       <= '0;
            prev      <= 1'b0;
            armed     <= 1'b0;
            seen_rise <= 1'b0;
            skip      <= 1'b0;
            pout_q    <= 1'b0;
        end else begin
            prev <= eff_in;
            if (!armed) begin
                if (rise_ev) seen_rise <= 1'b1;
                if (fall_ev && seen_rise) armed <= 1'b1;
            end
            if (set_skip) skip <= 1'b1;
            else if (clr_skip) skip <= 1'b0;
            if (fire) begin
                pout_q <= q[head].lvl;
                head   <= head + 1'b1;
            end
            if (push) begin
                q[tail] <= push_ev;
                tail    <= tail + 1'b1;
            end else if (drop) begin
                tail <= tail - 1'b1;
            end
            cnt <= cnt + CNT_W'(push) - CNT_W'(fire) - CNT_W'(drop);
        end
    end

    assign pout      = pout_q;
    assign not_armed = ~armed;

endmodule

// File: rtl/edge_dly_top.sv
`timescale 1ns/1ps
module edge_dly_top
    import edge_dly_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8,
    parameter int STEP   = 2,
    parameter int QDEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel_lo,
    input  logic [1:0]               sel_hi,
    input  logic                     fanout_en,
    input  logic [NUM_CH*CODE_W-1:0] dly_code,
    input  logic [NUM_CH*CODE_W-1:0] wid_code,
    input  logic [NUM_CH-1:0]        pulse_in,
    output logic [NUM_CH-1:0]        pulse_out,
    output logic [NUM_CH-1:0]        not_armed,
    output logic                     mode_bad
);

    localparam int MAX_SPAN = SPAN_EXT_NS * STEP;
    localparam int TIME_W   = $clog2(MAX_SPAN + 1) + 1;
    localparam int MERGE_CH = 1;

    logic [TIME_W-1:0] now;
    dmode_e            mode;

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end

    edge_dly_mode_dec u_dec (
        .sel_lo (sel_lo),
        .sel_hi (sel_hi),
        .mode   (mode),
        .bad    (mode_bad)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic              eff;
        logic [TIME_W-1:0] rd, fd;
        logic              acc;

        assign eff = pulse_in[g] | (fanout_en & pulse_in[MERGE_CH]);

        edge_dly_calc #(.CODE_W(CODE_W), .STEP(STEP), .TIME_W(TIME_W)) u_calc (
            .mode     (mode),
            .dly_code (dly_code[g*CODE_W +: CODE_W]),
            .wid_code (wid_code[g*CODE_W +: CODE_W]),
            .rise_dly (rd),
            .fall_dly (fd),
            .accept   (acc)
        );

        edge_dly_chan #(.TIME_W(TIME_W), .QDEPTH(QDEPTH)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .eff_in    (eff),
            .now       (now),
            .accept    (acc),
            .rise_dly  (rd),
            .fall_dly  (fd),
            .pout      (pulse_out[g]),
            .not_armed (not_armed[g])
        );
    end

endmodule

// File: rtl/edge_dly_chk.sv
`timescale 1ns/1ps
module edge_dly_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_lo,
    input logic [1:0]        sel_hi,
    input logic [NUM_CH-1:0] pulse_out,
    input logic [NUM_CH-1:0] not_armed,
    input logic              mode_bad
);

    // R2
    binary_sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_hi[1] == 1'b0) |-> !mode_bad);

    // R2
    extended_sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_hi == 2'b10 && sel_lo) |-> !mode_bad);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R7
        unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            not_armed[c] |-> !pulse_out[c]);

        // R7
        armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            !not_armed[c] |=> !not_armed[c]);

        // R7
        rise_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_out[c]) |-> !not_armed[c]);
    end

endmodule

bind edge_dly_top edge_dly_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .pulse_out (pulse_out),
    .not_armed (not_armed),
    .mode_bad  (mode_bad)
);

// File: tb/edge_dly_top_tb.sv
`timescale 1ns/1ps
module edge_dly_top_tb;

    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int STP = 2;
    localparam int QD  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              sel_lo;
    logic [1:0]        sel_hi;
    logic              fanout_en;
    logic [NCH*CW-1:0] dly_code, wid_code;
    logic [NCH-1:0]    pulse_in;
    logic [NCH-1:0]    pulse_out, not_armed;
    logic              mode_bad;

    logic [CW-1:0] dc [NCH];
    logic [CW-1:0] wc [NCH];

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            dly_code[c*CW +: CW] = dc[c];
            wid_code[c*CW +: CW] = wc[c];
        end
    end

    edge_dly_top #(.NUM_CH(NCH), .CODE_W(CW), .STEP(STP), .QDEPTH(QD)) u_dut (
        .clk(clk), .rst(rst), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .fanout_en(fanout_en), .dly_code(dly_code), .wid_code(wid_code),
        .pulse_in(pulse_in), .pulse_out(pulse_out), .not_armed(not_armed),
        .mode_bad(mode_bad)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // reference model state
    int qt [NCH][QD];
    bit ql [NCH][QD];
    int qn [NCH];
    bit m_out [NCH];
    bit m_prev[NCH];
    bit m_arm [NCH];
    bit m_seen[NCH];
    bit m_skip[NCH];
    int kcyc;

    function automatic int b_mode(bit lo, bit [1:0] hi);
        case (hi)
            2'b00: return lo ? 1 : 0;
            2'b01: return lo ? 3 : 2;
            2'b10: return lo ? 5 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic int b_span(int m);
        if (m == 0 || m == 2) return 19 * STP;
        if (m == 1 || m == 3) return 31 * STP;
        if (m == 5) return 45 * STP;
        return 0;
    endfunction

    function automatic int b_lin(int n, int d, int s);
        return 1 + (n * (s - 1)) / d;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            qn[c] = 0; m_out[c] = 0; m_prev[c] = 0;
            m_arm[c] = 0; m_seen[c] = 0; m_skip[c] = 0;
        end
        kcyc = 0;
    endtask

    task automatic model_step();
        int m, s, base, rd, fd, n0, lt;
        bit ok, ll, e, rise, fall;
        m = b_mode(sel_lo, sel_hi);
        s = b_span(m);
        for (int c = 0; c < NCH; c++) begin
            e  = pulse_in[c] | (fanout_en & pulse_in[1]);
            n0 = qn[c];
            lt = (n0 > 0) ? qt[c][n0-1] : 0;
            ll = (n0 > 0) ? ql[c][n0-1] : 0;
            if (qn[c] > 0 && qt[c][0] == kcyc) begin
                m_out[c] = ql[c][0];
                for (int i = 0; i < QD - 1; i++) begin
                    qt[c][i] = qt[c][i+1];
                    ql[c][i] = ql[c][i+1];
                end
                qn[c]--;
            end
            rise = e & !m_prev[c];
            fall = !e & m_prev[c];
            ok = (m >= 0);
            base = (s > 0) ? b_lin(int'(dc[c]), 255, s) : 1;
            case (m)
                0, 1: begin rd = base; fd = base; end
                2, 3: begin
                    rd = base;
                    fd = base + int'(wc[c]) - 128;
                    if (fd < 1) fd = 1;
                    if (fd > s) fd = s;
                end
                5: begin rd = b_lin(int'(dc[c]) + int'(wc[c]), 510, s); fd = rd; end
                default: begin rd = 1; fd = 1; end
            endcase
            if (m_arm[c]) begin
                if (rise) begin
                    if (!ok || n0 > QD - 2 || (n0 > 0 && kcyc + rd <= lt)) m_skip[c] = 1;
                    else begin
                        qt[c][qn[c]] = kcyc + rd; ql[c][qn[c]] = 1; qn[c]++;
                    end
                end
                if (fall) begin
                    if (m_skip[c]) m_skip[c] = 0;
                    else if (n0 > 0 && ll && kcyc + fd <= lt) qn[c]--;
                    else begin
                        qt[c][qn[c]] = kcyc + fd; ql[c][qn[c]] = 0; qn[c]++;
                    end
                end
            end else begin
                if (rise) m_seen[c] = 1;
                if (fall && m_seen[c]) m_arm[c] = 1;
            end
            m_prev[c] = e;
        end
        kcyc++;
    endtask

    task automatic compare();
        logic [NCH-1:0] eo, en;
        for (int c = 0; c < NCH; c++) begin
            eo[c] = m_out[c];
            en[c] = !m_arm[c];
        end
        checks++;
        if (pulse_out !== eo || not_armed !== en) begin
            fails++;
            $display("FAIL %s cycle %0d: out=%b armN=%b expected out=%b armN=%b",
                     cur_req, kcyc, pulse_out, not_armed, eo, en);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse(logic [NCH-1:0] mask, int width, int gap);
        pulse_in = mask;
        ticks(width);
        pulse_in = '0;
        ticks(gap);
    endtask

    task automatic set_mode(bit lo, bit [1:0] hi);
        sel_lo = lo;
        sel_hi = hi;
    endtask

    task automatic check_bad(bit lo, bit [1:0] hi);
        set_mode(lo, hi);
        #1;
        checks++;
        if (mode_bad !== (b_mode(lo, hi) < 0)) begin
            fails++;
            $display("FAIL R2 sel_hi=%b sel_lo=%b: mode_bad=%b expected %b",
                     hi, lo, mode_bad, (b_mode(lo, hi) < 0));
        end
    endtask

    task automatic set_codes(int ch, int d, int w);
        dc[ch] = CW'(d);
        wc[ch] = CW'(w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sel_lo = 0; sel_hi = 2'b00; fanout_en = 0; pulse_in = '0;
        for (int c = 0; c < NCH; c++) set_codes(c, 0, 128);
        repeat (3) @(negedge clk);
        // R1 reset values
        cur_req = "R1";
        checks++;
        if (pulse_out !== '0 || not_armed !== '1) begin
            fails++;
            $display("FAIL R1 reset: out=%b armN=%b expected out=0000 armN=1111",
                     pulse_out, not_armed);
        end
        rst = 1'b0;
        model_reset();
        tick();

        // R2 select decoding
        for (int h = 0; h < 4; h++)
            for (int l = 0; l < 2; l++) check_bad(l[0], h[1:0]);
        set_mode(0, 2'b00);

        // R7 arming: first pulse consumed
        cur_req = "R7";
        set_codes(0, 0, 128);
        pulse(4'b0001, 1, 3);
        pulse(4'b1110, 3, 4);
        pulse(4'b0001, 2, 4);
        pulse(4'b0001, 2, 4);

        // R3 modes 0/1, width ignored
        cur_req = "R3";
        set_codes(0, 0, 255);  set_codes(1, 255, 0);
        set_codes(2, 128, 17); set_codes(3, 60, 200);
        pulse(4'b1111, 5, 70);
        set_mode(1, 2'b00);
        set_codes(0, 255, 3);
        pulse(4'b1111, 8, 75);

        // R8 minimum and maximum latency
        cur_req = "R8";
        set_mode(0, 2'b00);
        set_codes(0, 0, 0);
        pulse(4'b0001, 1, 4);
        pulse(4'b0001, 3, 4);

        // R4 independent edges with clamps
        cur_req = "R4";
        set_mode(0, 2'b01);
        set_codes(0, 100, 140); set_codes(1, 255, 255);
        set_codes(2, 10, 0);    set_codes(3, 128, 100);
        pulse(4'b1111, 20, 70);
        set_mode(1, 2'b01);
        pulse(4'b1111, 30, 90);

        // R5 extended mode
        cur_req = "R5";
        set_mode(1, 2'b10);
        set_codes(0, 255, 255); set_codes(1, 0, 0);
        set_codes(2, 100, 50);  set_codes(3, 10, 240);
        pulse(4'b1111, 6, 100);

        // R6 merge from channel 2
        cur_req = "R6";
        set_mode(0, 2'b00);
        for (int c = 0; c < NCH; c++) set_codes(c, 40 * c, 128);
        fanout_en = 1;
        pulse(4'b0010, 4, 40);
        pulse(4'b1000, 2, 40);
        fanout_en = 0;
        pulse(4'b0010, 4, 40);

        // R9 crossed edges dropped
        cur_req = "R9";
        set_mode(0, 2'b01);
        set_codes(0, 255, 0);
        pulse(4'b0001, 2, 45);
        pulse(4'b0001, 40, 45);

        // R10 full queue and invalid mode
        cur_req = "R10";
        set_mode(1, 2'b00);
        set_codes(0, 255, 0);
        for (int i = 0; i < 4; i++) pulse(4'b0001, 1, 1);
        ticks(70);
        pulse(4'b0001, 1, 2);
        set_mode(0, 2'b10);
        pulse(4'b0001, 3, 3);
        set_mode(0, 2'b00);
        pulse(4'b0001, 3, 70);

        // R11 late code changes do not move queued edges
        cur_req = "R11";
        set_mode(0, 2'b00);
        set_codes(0, 200, 128);
        pulse_in = 4'b0001;
        ticks(3);
        set_codes(0, 20, 128);
        pulse_in = 4'b0000;
        ticks(3);
        set_mode(1, 2'b01);
        ticks(60);

        // R8 random traffic
        cur_req = "R8";
        for (int t = 0; t < 4000; t++) begin
            if (t % 250 == 0) begin
                set_mode(1'($urandom), 2'($urandom));
                fanout_en = 1'($urandom % 4 == 0);
                for (int c = 0; c < NCH; c++) set_codes(c, $urandom % 256, $urandom % 256);
            end
            for (int c = 0; c < NCH; c++)
                if ($urandom % 7 == 0) pulse_in[c] = ~pulse_in[c];
            tick();
        end
        pulse_in = '0;
        ticks(100);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule